// File: doc/BRIEF.md
# Strobe Sequencer for Asynchronous-Bus DRAM

This block turns the strobes of an asynchronous 16-bit processor bus into the control timing for one page of dynamic memory. It samples the bus with a 100 MHz clock, so every timing decision falls on a 10 ns tick. When the board select is high and the address strobe is seen low, the block starts a memory cycle. It sequences the row strobe, the row/column address multiplexer, the per-byte column strobes and the memory write enable. It also controls when the data bus drivers are enabled.

The host bus acknowledges on its own unless a device holds it off. The block pulls an active-low override line as soon as it sees a selected cycle. It releases the override once data can be ready, and then drives its own active-low acknowledge until the processor lifts the address strobe. The override is the only back-pressure: there is no valid/ready channel. A held override stretches the bus cycle for as long as the block needs. This happens while the row strobe finishes its precharge, and when a cycle arrives during a refresh. Refresh is started by a free-running interval counter, uses column-before-row ordering, and only begins while the address strobe is high.

Tick k below means the k-th rising clock edge after the edge that first samples a selected, low address strobe (tick 0). Output levels are the levels held after that edge. The block's own states decide its outputs, except for the override, which also reacts at once to the inputs.

Top module: `dram_strobe_seq`

## Requirements
- R1: After reset, the row strobe, both column strobes, the override, the acknowledge and the write enable are high, the multiplexer selects the row address (`mem_addr_col` = 0) and the data drivers are off.
- R2: With select high, the row strobe goes low at tick 2 of a cycle that starts with precharge complete.
- R3: A low address strobe while select is low has no effect: the override, the acknowledge and the row strobe stay high.
- R4: `mem_addr_col` goes to 1 (column address) at tick 3. The column strobes go low at tick 7, five ticks after the row strobe.
- R5: The override is low from the moment a selected cycle is seen until tick 8, and high from tick 9. The acknowledge is low from tick 10 until the edge that samples the address strobe high, and is released at that edge. The override and the acknowledge are never low together.
- R6: The row strobe, the column strobes and the multiplexer return to their idle levels one tick after the acknowledge is released.
- R7: In a read (`bus_rw` = 1), the data drivers turn on at tick 11. They stay on for 15 ticks after the edge that samples the address strobe high, unless a new selected cycle is detected first.
- R8: `mem_cas_hi_n` is asserted only if the upper byte strobe was low, and `mem_cas_lo_n` only if the lower byte strobe was low. Both strobes are sampled at tick 0.
- R9: In a write (`bus_rw` = 0), the data drivers stay off, and the write enable is low from tick 2 until the row strobe is released.
- R10: The row strobe is high for at least 8 ticks between any two of its low phases. A selected cycle that arrives early waits with the override held low, so that its row strobe falls exactly 8 ticks after the previous release.
- R11: A refresh is requested every 1560 ticks and starts only when the bus is idle with the address strobe high. Both column strobes go low one tick after the start and the row strobe two ticks after them. All strobes are high again 8 ticks after the start.
- R12: A selected cycle that arrives during a refresh gets the override low at once. Its acknowledge falls 24 ticks after the refresh start: that is the end of the refresh, plus precharge, plus the normal cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_uds_n | input | 1 | Upper byte strobe, active low |
| bus_lds_n | input | 1 | Lower byte strobe, active low |
| bus_sel | input | 1 | Board select from the address decode |
| bus_ovr_n | output | 1 | Override that holds off the default acknowledge, active low |
| bus_dtack_n | output | 1 | Data-transfer acknowledge, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_hi_n | output | 1 | Column strobe for the upper byte, active low |
| mem_cas_lo_n | output | 1 | Column strobe for the lower byte, active low |
| mem_addr_col | output | 1 | Address multiplexer: 0 = row, 1 = column |
| mem_we_n | output | 1 | Memory write enable, active low |
| bus_data_oe | output | 1 | Data bus driver enable (1 = driven) |

## Verification
A full read with both bytes is compared, tick by tick, against a table of all six bus and memory strobe levels. Any shift in an offset therefore shows up as a mismatch on a named tick. A write that selects only the upper byte tells the lanes apart from each other and write enable apart from the data driver. A low address strobe without select shows that the decode gate is respected. A cycle started right after the previous one ends, and another started in the middle of a refresh, show that precharge and refresh both stall through the override and not by dropping the cycle. Comparing two refresh starts measures the refresh interval.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_ACT,
    S_END,
    S_REFR
  } seq_state_e;
endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int PERIOD = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  output logic pend_o
);
  localparam int TW = $clog2(PERIOD);
  localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);

  logic [TW-1:0] tcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt   <= '0;
      pend_o <= 1'b0;
    end else begin
      tcnt <= (tcnt == LAST) ? '0 : tcnt + 1'b1;
      if (tcnt == LAST) pend_o <= 1'b1;
      else if (take_i)  pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/precharge_guard.sv
module precharge_guard #(
  parameter int PRE_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n_i,
  output logic ok_o
);
  localparam int PW = $clog2(PRE_TICKS + 1);
  localparam logic [PW-1:0] SAT = PW'(PRE_TICKS);
  // A cycle may start at an edge that sees this many high ticks: its row
  // strobe falls two ticks later, the release itself costs one more.
  localparam logic [PW-1:0] START_OK = PW'(PRE_TICKS - 3);

  logic [PW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            hi_cnt <= SAT;
    else if (!ras_n_i)     hi_cnt <= '0;
    else if (hi_cnt != SAT) hi_cnt <= hi_cnt + 1'b1;
  end

  assign ok_o = (hi_cnt >= START_OK);
endmodule

// File: rtl/drive_hold.sv
module drive_hold #(
  parameter int HOLD_TICKS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic clear_i,
  output logic busy_o
);
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam logic [HW-1:0] LOADV = HW'(HOLD_TICKS);

  logic [HW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           left <= '0;
    else if (clear_i)     left <= '0;
    else if (load_i)      left <= LOADV;
    else if (left != '0)  left <= left - 1'b1;
  end

  assign busy_o = (left != '0);
endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
  import dram_seq_pkg::*;
#(
  parameter int RAS_AT         = 2,
  parameter int CAS_GAP        = 5,
  parameter int OVR_TICKS      = 9,
  parameter int HOLD_TICKS     = 15,
  parameter int REFRESH_PERIOD = 1560,
  parameter int PRECHARGE      = 8,
  parameter int REF_LEN        = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_as_n,
  input  logic bus_rw,
  input  logic bus_uds_n,
  input  logic bus_lds_n,
  input  logic bus_sel,
  output logic bus_ovr_n,
  output logic bus_dtack_n,
  output logic mem_ras_n,
  output logic mem_cas_hi_n,
  output logic mem_cas_lo_n,
  output logic mem_addr_col,
  output logic mem_we_n,
  output logic bus_data_oe
);
  localparam int CAS_AT     = RAS_AT + CAS_GAP;
  localparam int MUX_AT     = RAS_AT + 1;
  localparam int DTACK_AT   = OVR_TICKS + 1;
  localparam int OE_AT      = OVR_TICKS + 2;
  localparam int REF_CAS_AT = 1;
  localparam int REF_RAS_AT = 3;
  localparam int CMAX       = (OE_AT > REF_LEN) ? OE_AT : REF_LEN;
  localparam int CW         = $clog2(CMAX + 1);
  localparam int KW         = $clog2(PRECHARGE + 1);

  localparam logic [CW-1:0] RAS_C  = CW'(RAS_AT);
  localparam logic [CW-1:0] CAS_C  = CW'(CAS_AT);
  localparam logic [CW-1:0] MUX_C  = CW'(MUX_AT);
  localparam logic [CW-1:0] OVR_C  = CW'(OVR_TICKS);
  localparam logic [CW-1:0] DT_C   = CW'(DTACK_AT);
  localparam logic [CW-1:0] OE_C   = CW'(OE_AT);
  localparam logic [CW-1:0] RCAS_C = CW'(REF_CAS_AT);
  localparam logic [CW-1:0] RRAS_C = CW'(REF_RAS_AT);
  localparam logic [CW-1:0] RLST_C = CW'(REF_LEN - 1);
  localparam logic [CW-1:0] CMAX_C = CW'(CMAX);

  seq_state_e    st;
  logic [CW-1:0] cnt;
  logic          rd_q, up_q, lo_q;
  logic          go_bus, prech_ok, ref_pend, ref_take;
  logic          hold_busy, hold_load, hold_clear;
  logic          in_cyc;

  assign go_bus = !bus_as_n && bus_sel;
  assign in_cyc = (st == S_ACT) || (st == S_END);

  assign ref_take   = (st == S_IDLE) && !go_bus && ref_pend && bus_as_n && prech_ok;
  assign hold_load  = (st == S_ACT) && bus_as_n && rd_q && (cnt >= OE_C);
  assign hold_clear = (st == S_IDLE) && go_bus;

  refresh_timer #(.PERIOD(REFRESH_PERIOD)) u_ref (
    .clk(clk), .rst_n(rst_n), .take_i(ref_take), .pend_o(ref_pend)
  );

  precharge_guard #(.PRE_TICKS(PRECHARGE)) u_pre (
    .clk(clk), .rst_n(rst_n), .ras_n_i(mem_ras_n), .ok_o(prech_ok)
  );

  drive_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk(clk), .rst_n(rst_n), .load_i(hold_load), .clear_i(hold_clear),
    .busy_o(hold_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      rd_q <= 1'b1;
      up_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (go_bus) begin
            st   <= prech_ok ? S_ACT : S_WAIT;
            cnt  <= '0;
            rd_q <= bus_rw;
            up_q <= !bus_uds_n;
            lo_q <= !bus_lds_n;
          end else if (ref_take) begin
            st  <= S_REFR;
            cnt <= '0;
          end
        end
        S_WAIT: begin
          if (bus_as_n) st <= S_IDLE;
          else if (prech_ok) begin
            st   <= S_ACT;
            cnt  <= '0;
            rd_q <= bus_rw;
            up_q <= !bus_uds_n;
            lo_q <= !bus_lds_n;
          end
        end
        S_ACT: begin
          if (bus_as_n)           st  <= S_END;
          else if (cnt != CMAX_C) cnt <= cnt + 1'b1;
        end
        S_END: st <= S_IDLE;
        S_REFR: begin
          if (cnt == RLST_C) st  <= S_IDLE;
          else               cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic ref_cas, ref_ras;
  assign ref_cas = (st == S_REFR) && (cnt >= RCAS_C);
  assign ref_ras = (st == S_REFR) && (cnt >= RRAS_C);

  assign mem_ras_n    = !((in_cyc && cnt >= RAS_C) || ref_ras);
  assign mem_cas_hi_n = !((in_cyc && cnt >= CAS_C && up_q) || ref_cas);
  assign mem_cas_lo_n = !((in_cyc && cnt >= CAS_C && lo_q) || ref_cas);
  assign mem_addr_col = in_cyc && (cnt >= MUX_C);
  assign mem_we_n     = !(in_cyc && !rd_q && cnt >= RAS_C);
  assign bus_ovr_n    = !((go_bus && (st == S_IDLE || st == S_REFR)) ||
                          (st == S_WAIT) ||
                          (st == S_ACT && cnt < OVR_C));
  assign bus_dtack_n  = !((st == S_ACT) && (cnt >= DT_C));
  assign bus_data_oe  = ((st == S_ACT) && rd_q && (cnt >= OE_C)) || hold_busy;

  // Row-high tick counter kept only for the precharge property.
  logic [KW-1:0] chk_hi;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          chk_hi <= KW'(PRECHARGE);
    else if (!mem_ras_n)                 chk_hi <= '0;
    else if (chk_hi != KW'(PRECHARGE))   chk_hi <= chk_hi + 1'b1;
  end

  assert_cas_after_ras_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_ras_n) && st == S_ACT) |-> (mem_cas_hi_n && mem_cas_lo_n));

  assert_ack_excludes_ovr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_dtack_n |-> bus_ovr_n);

  assert_ras_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_dtack_n) |=> $rose(mem_ras_n));

  assert_write_no_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !bus_data_oe);

  assert_precharge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ras_n) |-> (chk_hi >= KW'(PRECHARGE)));

  assert_cbr_order_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_ras_n) && st == S_REFR) |-> (!mem_cas_hi_n && !mem_cas_lo_n));
endmodule

// File: tb/dram_strobe_seq_tb.sv
module dram_strobe_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic as_n = 1'b1, rw = 1'b1, uds_n = 1'b1, lds_n = 1'b1, sel = 1'b0;
  logic ovr_n, dtack_n, ras_n, cas_hi_n, cas_lo_n, addr_col, we_n, data_oe;
  int checks = 0;
  int errors = 0;
  int tick = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) tick <= tick + 1;

  dram_strobe_seq dut_i (
    .clk(clk), .rst_n(rst_n), .bus_as_n(as_n), .bus_rw(rw),
    .bus_uds_n(uds_n), .bus_lds_n(lds_n), .bus_sel(sel),
    .bus_ovr_n(ovr_n), .bus_dtack_n(dtack_n), .mem_ras_n(ras_n),
    .mem_cas_hi_n(cas_hi_n), .mem_cas_lo_n(cas_lo_n),
    .mem_addr_col(addr_col), .mem_we_n(we_n), .bus_data_oe(data_oe)
  );

  // Per-tick read expectation: {ovr_n, ras_n, addr_col, cas_n, dtack_n, oe}
  localparam logic [5:0] RD_VEC [0:12] = '{
    6'b010110, 6'b010110, 6'b000110, 6'b001110, 6'b001110, 6'b001110,
    6'b001110, 6'b001010, 6'b001010, 6'b101010, 6'b101000, 6'b101001,
    6'b101001
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_ticks(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wait_refresh(output int at);
    at = -1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (cas_lo_n == 1'b0 && ras_n == 1'b1) begin
        at = tick;
        break;
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int r0, r1, first_dt, ovr_bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset levels
    chk("R1 ras", ras_n, 1);
    chk("R1 cas", {cas_hi_n, cas_lo_n}, 3);
    chk("R1 ovr/dtack", {ovr_n, dtack_n}, 3);
    chk("R1 mux/we/oe", {addr_col, we_n, data_oe}, 2);

    // R3 unselected strobe
    as_n = 1'b0; sel = 1'b0;
    for (int k = 0; k < 12; k++) begin
      step();
      chk("R3 no response", {ovr_n, dtack_n, ras_n}, 7);
    end
    as_n = 1'b1;
    idle_ticks(12);

    // Table-driven read, both lanes: R2 R4 R5 R8
    as_n = 1'b0; sel = 1'b1; rw = 1'b1; uds_n = 1'b0; lds_n = 1'b0;
    for (int k = 0; k <= 12; k++) begin
      step();
      chk($sformatf("R2/R4/R5 read tick %0d", k),
          {ovr_n, ras_n, addr_col, cas_hi_n, dtack_n, data_oe}, RD_VEC[k]);
      chk($sformatf("R8 lanes tick %0d", k), cas_lo_n, cas_hi_n);
    end
    as_n = 1'b1;
    step();
    chk("R5 ack release", dtack_n, 1);
    chk("R6 ras held one tick", ras_n, 0);
    step();
    chk("R6 strobes idle", {ras_n, cas_hi_n, cas_lo_n, addr_col}, 14);
    for (int j = 2; j <= 15; j++) begin
      step();
      chk($sformatf("R7 hold %0d", j), data_oe, (j < 15) ? 1 : 0);
    end
    idle_ticks(5);

    // Write, upper lane only: R8 R9
    rw = 1'b0; uds_n = 1'b0; lds_n = 1'b1; as_n = 1'b0;
    for (int k = 0; k <= 12; k++) begin
      step();
      chk($sformatf("R8 upper tick %0d", k), cas_hi_n, (k >= 7) ? 0 : 1);
      chk($sformatf("R8 lower tick %0d", k), cas_lo_n, 1);
      chk($sformatf("R9 we tick %0d", k), we_n, (k >= 2) ? 0 : 1);
      chk($sformatf("R9 no drive tick %0d", k), data_oe, 0);
    end
    as_n = 1'b1;
    step();
    chk("R9 we during release", we_n, 0);
    step();
    chk("R9 we released", we_n, 1);
    idle_ticks(20);

    // Back-to-back read: R10
    rw = 1'b1; uds_n = 1'b0; lds_n = 1'b0; as_n = 1'b0;
    idle_ticks(13);
    as_n = 1'b1;
    step();
    step();
    as_n = 1'b0;
    for (int j = 2; j <= 17; j++) begin
      step();
      if (j <= 8) chk($sformatf("R10 precharge %0d", j), {ras_n, ovr_n}, 2);
      if (j == 9) chk("R10 ras after 8", ras_n, 0);
      if (j == 16) chk("R10 ack not yet", dtack_n, 1);
      if (j == 17) chk("R10 ack delayed", dtack_n, 0);
    end
    as_n = 1'b1;

    // Refresh: R11
    wait_refresh(r0);
    chk("R11 refresh seen", (r0 > 0) ? 1 : 0, 1);
    chk("R11 cbr both lanes", cas_hi_n, 0);
    step();
    chk("R11 ras still high", ras_n, 1);
    step();
    chk("R11 ras two after cas", ras_n, 0);
    idle_ticks(5);
    chk("R11 refresh done", {ras_n, cas_hi_n, cas_lo_n}, 7);

    // Collision with the next refresh: R11 period, R12
    wait_refresh(r1);
    chk("R11 period", r1 - r0, 1560);
    as_n = 1'b0; sel = 1'b1; rw = 1'b1;
    #1;
    chk("R12 immediate override", ovr_n, 0);
    first_dt = -1;
    ovr_bad = 0;
    for (int j = 2; j <= 26; j++) begin
      step();
      if (j <= 22 && ovr_n !== 1'b0) ovr_bad++;
      if (first_dt < 0 && dtack_n == 1'b0) first_dt = j;
    end
    chk("R12 override held", ovr_bad, 0);
    chk("R12 ack tick", first_dt, 24);
    as_n = 1'b1;
    idle_ticks(20);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule